// File: doc/BRIEF.md
# SMBus Stuck-Line Guard

This block sits beside the serial interface of an SMBus target. It watches the clock and data lines after they have been synchronized into the core clock domain. It also counts how long each line has been low, in units of a slow timing tick. If either line stays low long enough, the guard sends a one-cycle reset pulse to the interface state machine. It also forces the target's open-drain pull-down requests off, so that both pins go to high impedance.

The guard keeps the pull-downs released until it sees both lines high in the same cycle. After that, the target's own requests pass through to the pads again. The trip count is a parameter and is clamped into a minimum/maximum window. A legitimate slow clock low phase therefore cannot trip the guard, and a real stuck bus is always caught within the allowed limit. With a 1 MHz tick, the defaults give a trip point of 30 000 ticks (30 ms) inside a window of 25 ms to 35 ms.

The sequencer has three states:

- `ST_WATCH`: normal operation.
- `ST_FIRE`: one cycle, in which the reset pulse is asserted.
- `ST_HOLD`: the pull-downs are forced off.

The transitions are:

- watch-to-fire, on a trip.
- fire-to-hold, always after one cycle.
- hold-to-watch, once both lines are seen high.
- Synchronous reset, which enters `ST_HOLD` from any state.

Top module: `smbus_stuck_guard`

## Requirements
- R1: With only the clock line (`scl_in`) low and `tick` high every cycle, the line is first sampled low at clock edge 1 and held low through edge T, where T is the effective trip count. `iface_reset` is then high after edge T+1.
- R2: The same trip timing applies when only the data line (`sda_in`) is held low for T or more edges.
- R3: The same trip timing applies when both lines are held low together for T or more edges.
- R4: A low run of fewer than T ticks on either line produces no `iface_reset` pulse and no release.
- R5: Whenever a line is sampled high, its low count restarts from zero. Two low runs of T-1 ticks separated by one high sample therefore do not trip.
- R6: Each line has its own low counter. A line that toggles does not delay or prevent a trip caused by the other line staying low.
- R7: `iface_reset` is high for exactly one cycle per trip.
- R8: `bus_release` is high from the cycle of the pulse until both lines have been sampled high at an edge, with a minimum of two cycles. While `bus_release` is high, `scl_pull` and `sda_pull` are 0. Otherwise each pull output equals its request input.
- R9: The low counters advance only in cycles where `tick` is 1. With `tick` held at 0, no low time trips the guard.
- R10: The effective trip count T is `TRIP_TICKS` clamped into the range [`MIN_TICKS`, `MAX_TICKS`].
- R11: A synchronous `rst` clears both counters and enters the hold state. While in reset, and until both lines are sampled high after reset, `bus_release` is 1 and `iface_reset` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timing tick enable; counters advance only when this is 1 |
| scl_in | input | 1 | Synchronized clock line level |
| sda_in | input | 1 | Synchronized data line level |
| scl_pull_req | input | 1 | Target requests the clock pad to be pulled low |
| sda_pull_req | input | 1 | Target requests the data pad to be pulled low |
| scl_pull | output | 1 | Gated pull-low enable to the clock pad |
| sda_pull | output | 1 | Gated pull-low enable to the data pad |
| iface_reset | output | 1 | One-cycle reset pulse to the interface state machine |
| bus_release | output | 1 | High while the pull-downs are forced off |

## Verification
The main bench instance uses `TRIP_TICKS`=8, `MIN_TICKS`=6 and `MAX_TICKS`=10, with the tick held high. This makes every low-run length from 1 up to T+6 cheap to sweep for each line and for both lines together. A second instance uses `TRIP_TICKS`=20 with the same window, so its effective trip count of 10 brings the clamp into the same sweep. Expected pulse and release cycles come from a closed-form function of the run length and T. Further dedicated runs cover:

- interrupted lows;
- one line toggling while the other is stuck;
- a held-off tick;
- a reset that lands in the middle of a count.

// File: rtl/stuck_guard_pkg.sv
package stuck_guard_pkg;

    // Sequencer states of the guard
    typedef enum logic [1:0] {
        ST_WATCH = 2'd0,
        ST_FIRE  = 2'd1,
        ST_HOLD  = 2'd2
    } guard_state_e;

    // Number of monitored lines: index 0 is the clock line, index 1 the data line
    localparam int unsigned NUM_LINES = 2;

    // Clamp a requested trip count into the permitted window
    function automatic int unsigned clamp_trip(
        input int unsigned req,
        input int unsigned lo,
        input int unsigned hi
    );
        if (req < lo) begin
            return lo;
        end else if (req > hi) begin
            return hi;
        end
        return req;
    endfunction

endpackage

// File: rtl/line_low_timer.sv
module line_low_timer #(
    parameter int unsigned LIMIT = 30000,
    parameter int unsigned CNT_W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic line_in,
    output logic expired
);

    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

    logic [CNT_W-1:0] low_cnt;

    assign expired = (low_cnt == LIMIT_V);

    // Counts ticks of continuous low; a high sample restarts it, saturates at LIMIT
    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
        end else if (line_in) begin
            low_cnt <= '0;
        end else if (tick && !expired) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/guard_sequencer.sv
module guard_sequencer
    import stuck_guard_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trip,
    input  logic both_high,
    output logic fire,
    output logic release_drv
);

    guard_state_e state_q;
    guard_state_e state_d;

    // State register: reset parks the guard in the hold state
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WATCH: if (trip)      state_d = ST_FIRE;
            ST_FIRE:                 state_d = ST_HOLD;
            ST_HOLD:  if (both_high) state_d = ST_WATCH;
            default:                 state_d = ST_HOLD;
        endcase
    end

    // Moore outputs
    always_comb begin
        fire        = 1'b0;
        release_drv = 1'b1;
        unique case (state_q)
            ST_WATCH: release_drv = 1'b0;
            ST_FIRE:  fire        = 1'b1;
            ST_HOLD:  release_drv = 1'b1;
            default:  release_drv = 1'b1;
        endcase
    end

endmodule

// File: rtl/pull_gate.sv
module pull_gate (
    input  logic pull_req,
    input  logic force_off,
    output logic pull_out
);

    assign pull_out = pull_req & ~force_off;

endmodule

// File: rtl/smbus_stuck_guard.sv
module smbus_stuck_guard
    import stuck_guard_pkg::*;
#(
    parameter int unsigned TRIP_TICKS = 30000,
    parameter int unsigned MIN_TICKS  = 25000,
    parameter int unsigned MAX_TICKS  = 35000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic scl_in,
    input  logic sda_in,
    input  logic scl_pull_req,
    input  logic sda_pull_req,
    output logic scl_pull,
    output logic sda_pull,
    output logic iface_reset,
    output logic bus_release
);

    localparam int unsigned EFF_TICKS = clamp_trip(TRIP_TICKS, MIN_TICKS, MAX_TICKS);
    localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

    logic [NUM_LINES-1:0] line_lvl;
    logic [NUM_LINES-1:0] line_req;
    logic [NUM_LINES-1:0] line_pull;
    logic [NUM_LINES-1:0] line_exp;
    logic                 any_trip;
    logic                 lines_high;

    assign line_lvl   = {sda_in, scl_in};
    assign line_req   = {sda_pull_req, scl_pull_req};
    assign any_trip   = |line_exp;
    assign lines_high = &line_lvl;

    // One low timer and one pull gate per line
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        line_low_timer #(
            .LIMIT (EFF_TICKS),
            .CNT_W (CNT_W)
        ) u_timer (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .line_in (line_lvl[g]),
            .expired (line_exp[g])
        );

        pull_gate u_gate (
            .pull_req  (line_req[g]),
            .force_off (bus_release),
            .pull_out  (line_pull[g])
        );
    end

    guard_sequencer u_seq (
        .clk         (clk),
        .rst         (rst),
        .trip        (any_trip),
        .both_high   (lines_high),
        .fire        (iface_reset),
        .release_drv (bus_release)
    );

    assign scl_pull = line_pull[0];
    assign sda_pull = line_pull[1];

endmodule

// File: rtl/stuck_guard_checker.sv
module stuck_guard_checker (
    input logic clk,
    input logic rst,
    input logic scl_in,
    input logic sda_in,
    input logic iface_reset,
    input logic bus_release
);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        iface_reset |=> !iface_reset); // R7

    AST_PULSE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        iface_reset |=> bus_release); // R8

    AST_HOLD_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
        (bus_release && !iface_reset && !(scl_in && sda_in)) |=> bus_release); // R8

    AST_EXIT_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_release) |-> $past(scl_in && sda_in)); // R8

    AST_PULSE_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(iface_reset) |-> $past(!scl_in || !sda_in, 2)); // R1

    AST_RESET_HOLDS: assert property (@(posedge clk)
        rst |=> (bus_release && !iface_reset)); // R11

endmodule

bind smbus_stuck_guard stuck_guard_checker u_stuck_guard_checker (
    .clk         (clk),
    .rst         (rst),
    .scl_in      (scl_in),
    .sda_in      (sda_in),
    .iface_reset (iface_reset),
    .bus_release (bus_release)
);

// File: tb/test_smbus_stuck_guard.sv
module test_smbus_stuck_guard;

    localparam int T_MAIN  = 8;
    localparam int T_CLAMP = 10; // 20 clamped into [6,10], R10

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic scl_in = 1'b1;
    logic sda_in = 1'b1;
    logic scl_req = 1'b0;
    logic sda_req = 1'b0;
    logic scl_pull, sda_pull, iface_reset, bus_release;
    logic c_scl_pull, c_sda_pull, c_iface_reset, c_bus_release;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    smbus_stuck_guard #(.TRIP_TICKS(8), .MIN_TICKS(6), .MAX_TICKS(10)) i_smbus_stuck_guard (
        .clk(clk), .rst(rst), .tick(tick), .scl_in(scl_in), .sda_in(sda_in),
        .scl_pull_req(scl_req), .sda_pull_req(sda_req),
        .scl_pull(scl_pull), .sda_pull(sda_pull),
        .iface_reset(iface_reset), .bus_release(bus_release)
    );

    smbus_stuck_guard #(.TRIP_TICKS(20), .MIN_TICKS(6), .MAX_TICKS(10)) i_smbus_stuck_guard_clamp (
        .clk(clk), .rst(rst), .tick(tick), .scl_in(scl_in), .sda_in(sda_in),
        .scl_pull_req(scl_req), .sda_pull_req(sda_req),
        .scl_pull(c_scl_pull), .sda_pull(c_sda_pull),
        .iface_reset(c_iface_reset), .bus_release(c_bus_release)
    );

    task automatic check(input logic got, input logic exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s at %0t: got %b expected %b", tag, $time, got, exp);
        end
    endtask

    // Pulse expected after edge e for a low run of L edges starting at edge 1
    function automatic bit exp_pulse(int t, int l, int e);
        return (l >= t) && (e == t + 1);
    endfunction

    function automatic bit exp_rel(int t, int l, int e);
        int last;
        last = (l > t + 2) ? l : t + 2;
        return (l >= t) && (e >= t + 1) && (e <= last);
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            scl_in = 1'b1;
            sda_in = 1'b1;
            step();
        end
    endtask

    // mask bit0: clock line low, bit1: data line low
    task automatic low_run(input int mask, input int l);
        string tag;
        for (int e = 1; e <= l + 5; e++) begin
            @(negedge clk);
            scl_in  = !(mask[0] && e <= l);
            sda_in  = !(mask[1] && e <= l);
            scl_req = e[0];
            sda_req = !e[0];
            step();
            tag = (mask == 1) ? "R1" : (mask == 2) ? "R2" : "R3";
            if (l < T_MAIN) tag = {tag, "/R4"};
            check(iface_reset, exp_pulse(T_MAIN, l, e), {tag, "/R7 pulse"});
            check(bus_release, exp_rel(T_MAIN, l, e), {tag, "/R8 release"});
            check(scl_pull, scl_req && !exp_rel(T_MAIN, l, e), "R8 scl_pull");
            check(sda_pull, sda_req && !exp_rel(T_MAIN, l, e), "R8 sda_pull");
            check(c_iface_reset, exp_pulse(T_CLAMP, l, e), "R10 clamp pulse");
            check(c_bus_release, exp_rel(T_CLAMP, l, e), "R10 clamp release");
        end
        idle(4);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        for (int i = 0; i < 3; i++) begin
            step();
            check(bus_release, 1'b1, "R11 release in reset");
            check(iface_reset, 1'b0, "R11 no pulse in reset");
        end
        @(negedge clk);
        rst = 1'b0;
        step();
        check(bus_release, 1'b0, "R11 exit after high lines");
        idle(2);

        // R1..R4, R7, R8, R10 sweep
        for (int m = 1; m <= 3; m++) begin
            for (int l = 1; l <= T_CLAMP + 4; l++) begin
                low_run(m, l);
            end
        end

        // R5: interrupted low runs
        for (int e = 1; e <= 2 * T_MAIN + 4; e++) begin
            @(negedge clk);
            scl_in = (e == T_MAIN) || (e > 2 * T_MAIN - 1);
            sda_in = 1'b1;
            step();
            check(iface_reset, 1'b0, "R5 restart no pulse");
            check(bus_release, 1'b0, "R5 restart no release");
        end
        idle(3);

        // R6: clock toggles while data is stuck
        for (int e = 1; e <= T_MAIN + 8; e++) begin
            @(negedge clk);
            sda_in = !(e <= T_MAIN + 3);
            scl_in = (e > T_MAIN + 3) ? 1'b1 : e[0] == 1'b0;
            step();
            check(iface_reset, exp_pulse(T_MAIN, T_MAIN + 3, e), "R6 pulse");
            check(bus_release, exp_rel(T_MAIN, T_MAIN + 3, e), "R6 release");
        end
        idle(6);

        // R9: tick held off
        @(negedge clk);
        tick = 1'b0;
        for (int e = 1; e <= 3 * T_MAIN; e++) begin
            @(negedge clk);
            scl_in = 1'b0;
            sda_in = 1'b0;
            step();
            check(iface_reset, 1'b0, "R9 no pulse without tick");
            check(bus_release, 1'b0, "R9 no release without tick");
        end
        idle(1);
        tick = 1'b1;
        idle(2);

        // R11: reset in mid-count
        for (int e = 1; e <= T_MAIN - 2; e++) begin
            @(negedge clk);
            scl_in = 1'b0;
            step();
        end
        @(negedge clk);
        rst = 1'b1;
        step();
        check(bus_release, 1'b1, "R11 reset mid count");
        @(negedge clk);
        rst = 1'b0;
        for (int e = 1; e <= 2 * T_MAIN; e++) begin
            step();
            check(iface_reset, 1'b0, "R11 no pulse after reset");
            check(bus_release, 1'b1, "R11 hold while low");
            @(negedge clk);
        end
        scl_in = 1'b1;
        step();
        check(bus_release, 1'b0, "R11 leave hold on high");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule